// File: doc/BRIEF.md
# I2C Target Front End for a Small ADC

This block is the serial-bus side of a small analog-to-digital converter. It watches the two bus wires in the system clock domain and pulls the data wire low through an open-drain enable. It never touches the clock wire. It recognises bus start, repeated start and stop events and compares the address byte with a fixed 7-bit identity. For a controller read it shifts out a 16-bit conversion result and the 8-bit configuration byte. For a controller write it takes one configuration byte.

Two special address bytes get their own handling. The general-call address carries a reset command, and the block turns that command into a single-cycle pulse. The high-speed controller code is never acknowledged and raises a mode flag that stays up until the next stop. The received configuration byte and the reset pulse go to a separate register and control block. That block owns the stored state and feeds back the result word and the configuration byte.

Top module: `i2c_adc_target`

## Requirements
- R1: The block answers only the address byte whose upper seven bits equal 100100x, where x is the ADDR_SEL parameter (0 or 1), and whose bit 0 selects read (1) or write (0). The block acknowledges such a byte by pulling SDA low in the ninth clock of the byte.
- R2: A falling SDA while SCL is high starts address reception, including when a transfer is already active. A rising SDA while SCL is high ends the transfer. The block releases SDA after either event.
- R3: A read transfer returns, MSB first, the upper byte of `result_word`, then its lower byte, then `cfg_byte`, then FFh for every further byte. The result and configuration values are captured once, when the address byte is decoded.
- R4: In a write transfer the first data byte is acknowledged and presented on `cfg_wdata` with a one-cycle `cfg_wr` pulse. Every later byte in that transfer is not acknowledged and produces no pulse.
- R5: The general-call address byte 00h is always acknowledged. A following data byte 06h is acknowledged and raises a one-cycle `dev_reset` pulse. A data byte 04h is acknowledged with no other effect. Any other data byte is not acknowledged and produces no pulse.
- R6: An address byte 00001xxx is not acknowledged and sets `hs_mode`. The flag stays set across repeated starts and clears at the next stop.
- R7: SDA is only ever pulled low or released, and it is pulled low only while SCL is low. The block has no SCL output.
- R8: When the controller leaves SDA high in the acknowledge clock of a read byte, the block releases SDA and sends nothing more until the next start or stop.
- R9: After an address byte that matches none of the cases above, the block leaves SDA released and ignores all bytes until the next start.
- R10: After reset SDA is released, `hs_mode` is 0, and neither `cfg_wr` nor `dev_reset` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock wire as seen at the pin |
| sda_i | input | 1 | Bus data wire as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data wire low, 0 releases it |
| result_word | input | 16 | Latest conversion result, sign-extended two's complement |
| cfg_byte | input | 8 | Current configuration byte from the register block |
| cfg_wr | output | 1 | One-cycle strobe: new configuration byte on cfg_wdata |
| cfg_wdata | output | 8 | Configuration byte received from the bus |
| dev_reset | output | 1 | One-cycle strobe: general-call reset command received |
| hs_mode | output | 1 | High-speed controller code seen since the last stop |

## Verification
The bench builds the block with ADDR_SEL = 1 and the default two synchronizer stages. This makes 1001001 the live identity, so the neighbouring address 1001000 serves as a realistic near-miss for the non-matching path. It also shows that the parameter actually reaches the compare rather than a hard-wired default. The bus is driven with eight system clocks per SCL phase. That is wide enough for the synchronizer and edge detector to resolve every edge, so each acknowledge and data bit the block drives can be sampled in the middle of the SCL high phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int RES_W  = 16;
    localparam int IDX_W  = 2;

    localparam logic [6:0]        ADDR_BASE = 7'b1001000;
    localparam logic [BYTE_W-1:0] GC_ADDR   = 8'h00;
    localparam logic [BYTE_W-1:0] GC_RESET  = 8'h06;
    localparam logic [BYTE_W-1:0] GC_LATCH  = 8'h04;
    localparam logic [4:0]        HS_PREFIX = 5'b00001;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_GDATA,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } tgt_state_e;

    // synchronized bus levels and events
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // outcome of a completed received byte
    typedef struct packed {
        logic       ack;
        tgt_state_e nxt;
        logic       rd;
        logic       hs;
        logic       wr_req;
        logic       rst_req;
    } rx_dec_t;

    function automatic rx_dec_t decode_addr(input logic [BYTE_W-1:0] b,
                                            input logic [6:0] own);
        rx_dec_t d;
        d     = '0;
        d.nxt = ST_IDLE;
        if (b[7:1] == own) begin
            d.ack = 1'b1;
            d.rd  = b[0];
            d.nxt = b[0] ? ST_TX : ST_WDATA;
        end else if (b == GC_ADDR) begin
            d.ack = 1'b1;
            d.nxt = ST_GDATA;
        end else if (b[7:3] == HS_PREFIX) begin
            d.hs  = 1'b1;
        end
        return d;
    endfunction

    function automatic rx_dec_t decode_gc(input logic [BYTE_W-1:0] b);
        rx_dec_t d;
        d     = '0;
        d.nxt = ST_IDLE;
        if (b == GC_RESET) begin
            d.ack     = 1'b1;
            d.rst_req = 1'b1;
        end else if (b == GC_LATCH) begin
            d.ack = 1'b1;
        end
        return d;
    endfunction

    function automatic rx_dec_t decode_wr();
        rx_dec_t d;
        d        = '0;
        d.nxt    = ST_IDLE;
        d.ack    = 1'b1;
        d.wr_req = 1'b1;
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_tx_byte(input logic [IDX_W-1:0] idx,
                                                       input logic [RES_W-1:0] res,
                                                       input logic [BYTE_W-1:0] cfg);
        case (idx)
            2'd0:    return res[RES_W-1:BYTE_W];
            2'd1:    return res[BYTE_W-1:0];
            2'd2:    return cfg;
            default: return FILL_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;
    localparam int SCL_L = 0;
    localparam int SDA_L = 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl      = synced[SCL_L];
        ev.sda      = synced[SDA_L];
        ev.scl_rise = synced[SCL_L] & ~prev[SCL_L];
        ev.scl_fall = ~synced[SCL_L] & prev[SCL_L];
        ev.start    = synced[SCL_L] & prev[SCL_L] & prev[SDA_L] & ~synced[SDA_L];
        ev.stop     = synced[SCL_L] & prev[SCL_L] & ~prev[SDA_L] & synced[SDA_L];
    end

endmodule

// File: rtl/i2c_tgt_rdsrc.sv
module i2c_tgt_rdsrc
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap,
    input  logic              adv,
    input  logic [RES_W-1:0]  result_word,
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic [BYTE_W-1:0] tx_byte
);

    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    logic [RES_W-1:0]  res_q;
    logic [BYTE_W-1:0] cfg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            cfg_q <= '0;
            idx_q <= '0;
        end else if (snap) begin
            res_q <= result_word;
            cfg_q <= cfg_byte;
            idx_q <= '0;
        end else if (adv && idx_q != IDX_LAST) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign tx_byte = pick_tx_byte(idx_q, res_q, cfg_q);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'b1001000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sda,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              cfg_wr,
    output logic [BYTE_W-1:0] cfg_wdata,
    output logic              dev_reset,
    output logic              hs_mode,
    output logic              rd_snap,
    output logic              rd_adv
);

    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    tgt_state_e        state;
    logic [2:0]        bit_cnt;
    logic              byte_done;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-2:0] txsh;
    logic              ack_q;
    tgt_state_e        nxt_q;
    logic              mack_q;

    logic [BYTE_W-1:0] rx_byte;
    rx_dec_t           cur;

    always_comb begin
        rx_byte = {shreg, ev_sda};
        case (state)
            ST_ADDR:  cur = decode_addr(rx_byte, OWN_ADDR);
            ST_GDATA: cur = decode_gc(rx_byte);
            default:  cur = decode_wr();
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            shreg     <= '0;
            txsh      <= '1;
            ack_q     <= 1'b0;
            nxt_q     <= ST_IDLE;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            cfg_wr    <= 1'b0;
            cfg_wdata <= '0;
            dev_reset <= 1'b0;
            hs_mode   <= 1'b0;
            rd_snap   <= 1'b0;
            rd_adv    <= 1'b0;
        end else begin
            cfg_wr    <= 1'b0;
            dev_reset <= 1'b0;
            rd_snap   <= 1'b0;
            rd_adv    <= 1'b0;
            if (ev_stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                hs_mode <= 1'b0;
            end else if (ev_start) begin
                state     <= ST_ADDR;
                sda_oe    <= 1'b0;
                bit_cnt   <= '0;
                byte_done <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA, ST_GDATA: begin
                        if (ev_rise && !byte_done) begin
                            shreg   <= rx_byte[BYTE_W-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                byte_done <= 1'b1;
                                ack_q     <= cur.ack;
                                nxt_q     <= cur.nxt;
                                if (cur.hs)      hs_mode   <= 1'b1;
                                if (cur.rd)      rd_snap   <= 1'b1;
                                if (cur.rst_req) dev_reset <= 1'b1;
                                if (cur.wr_req) begin
                                    cfg_wr    <= 1'b1;
                                    cfg_wdata <= rx_byte;
                                end
                            end
                        end else if (ev_fall && byte_done) begin
                            byte_done <= 1'b0;
                            sda_oe    <= ack_q;
                            state     <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (ev_fall) begin
                            bit_cnt   <= '0;
                            byte_done <= 1'b0;
                            if (ack_q && nxt_q == ST_TX) begin
                                txsh   <= tx_byte[BYTE_W-2:0];
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                rd_adv <= 1'b1;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ack_q ? nxt_q : ST_IDLE;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_rise && !byte_done) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
                        end else if (ev_fall) begin
                            if (byte_done) begin
                                byte_done <= 1'b0;
                                sda_oe    <= 1'b0;
                                mack_q    <= 1'b0;
                                state     <= ST_TXACK;
                            end else begin
                                sda_oe <= ~txsh[BYTE_W-2];
                                txsh   <= {txsh[BYTE_W-3:0], 1'b1};
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev_rise) begin
                            mack_q <= ~ev_sda;
                        end else if (ev_fall) begin
                            bit_cnt <= '0;
                            if (mack_q) begin
                                txsh   <= tx_byte[BYTE_W-2:0];
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                rd_adv <= 1'b1;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_adc_target.sv
module i2c_adc_target
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_SEL    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [RES_W-1:0]  result_word,
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic              cfg_wr,
    output logic [BYTE_W-1:0] cfg_wdata,
    output logic              dev_reset,
    output logic              hs_mode
);

    localparam logic [6:0] OWN_ADDR = {ADDR_BASE[6:1], ADDR_SEL[0]};

    bus_ev_t           ev;
    logic              rd_snap;
    logic              rd_adv;
    logic [BYTE_W-1:0] tx_byte;
    logic              scl_q;
    logic              start_q;
    logic              stop_q;

    assign scl_q   = ev.scl;
    assign start_q = ev.start;
    assign stop_q  = ev.stop;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_rdsrc u_rdsrc (
        .clk         (clk),
        .rst         (rst),
        .snap        (rd_snap),
        .adv         (rd_adv),
        .result_word (result_word),
        .cfg_byte    (cfg_byte),
        .tx_byte     (tx_byte)
    );

    i2c_tgt_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_sda    (ev.sda),
        .ev_rise   (ev.scl_rise),
        .ev_fall   (ev.scl_fall),
        .ev_start  (start_q),
        .ev_stop   (stop_q),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .dev_reset (dev_reset),
        .hs_mode   (hs_mode),
        .rd_snap   (rd_snap),
        .rd_adv    (rd_adv)
    );

endmodule

// File: rtl/i2c_adc_target_chk.sv
module i2c_adc_target_chk (
    input logic clk,
    input logic rst,
    input logic scl_q,
    input logic start_q,
    input logic stop_q,
    input logic sda_oe,
    input logic cfg_wr,
    input logic dev_reset,
    input logic hs_mode
);

    // R7: the data wire is pulled low only while the clock wire is low
    assert_pull_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(!scl_q));

    // R2: a start releases the data wire
    assert_start_release_R2: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !sda_oe);

    // R2: a stop releases the data wire
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
        stop_q |=> !sda_oe);

    // R6: the high-speed flag is clear after a stop
    assert_hs_stop_clear_R6: assert property (@(posedge clk) disable iff (rst)
        stop_q |=> !hs_mode);

    // R4: the write strobe lasts one cycle
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_wr);

    // R5: the reset strobe lasts one cycle and never coincides with a write
    assert_gc_single_R5: assert property (@(posedge clk) disable iff (rst)
        dev_reset |=> !dev_reset);

    assert_gc_excl_R5: assert property (@(posedge clk) disable iff (rst)
        dev_reset |-> !cfg_wr);

endmodule

bind i2c_adc_target i2c_adc_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_q     (scl_q),
    .start_q   (start_q),
    .stop_q    (stop_q),
    .sda_oe    (sda_oe),
    .cfg_wr    (cfg_wr),
    .dev_reset (dev_reset),
    .hs_mode   (hs_mode)
);

// File: tb/i2c_adc_target_tb.sv
`timescale 1ns/1ps
module i2c_adc_target_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] result_word = 16'h0000;
    logic [7:0]  cfg_byte = 8'h80;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic        dev_reset;
    logic        hs_mode;
    wire         sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int gc_cnt = 0;
    int oe_rises = 0;
    int oe_bad = 0;
    logic [7:0] wr_last = 8'h00;
    logic oe_d = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_adc_target #(.ADDR_SEL(1), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .result_word (result_word),
        .cfg_byte    (cfg_byte),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .dev_reset   (dev_reset),
        .hs_mode     (hs_mode)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_wr) begin wr_cnt++; wr_last = cfg_wdata; end
            if (dev_reset) gc_cnt++;
            if (sda_oe && !oe_d) begin
                oe_rises++;
                if (scl) oe_bad++;
            end
        end
        oe_d = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic v, output logic s);
        repeat (4) @(negedge clk); sda_m = v;
        repeat (4) @(negedge clk); scl = 1'b1;
        repeat (4) @(negedge clk); s = sda_line;
        repeat (4) @(negedge clk); scl = 1'b0;
    endtask

    task automatic bus_start();
        repeat (4) @(negedge clk); sda_m = 1'b1;
        repeat (4) @(negedge clk); scl = 1'b1;
        repeat (8) @(negedge clk); sda_m = 1'b0;
        repeat (8) @(negedge clk); scl = 1'b0;
    endtask

    task automatic bus_stop();
        repeat (4) @(negedge clk); sda_m = 1'b0;
        repeat (4) @(negedge clk); scl = 1'b1;
        repeat (8) @(negedge clk); sda_m = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
        chk(hs_mode == 1'b0, "R10 hs flag", hs_mode, 0);
        chk(wr_cnt == 0, "R10 no write strobe", wr_cnt, 0);
        chk(gc_cnt == 0, "R10 no reset strobe", gc_cnt, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        logic [7:0] exp [5];
        result_word = 16'hFA5C;
        cfg_byte    = 8'h8A;
        exp = '{8'hFA, 8'h5C, 8'h8A, 8'hFF, 8'hFF};
        bus_start();
        send_byte(8'h93, a);
        chk(a == 1'b1, "R1 read address ack", a, 1);
        for (int k = 0; k < 5; k++) begin
            recv_byte(k != 4, b);
            chk(b == exp[k], "R3 read byte", b, exp[k]);
        end
        bus_stop();
    endtask

    task automatic t_write();
        logic a;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h92, a);
        chk(a == 1'b1, "R1 write address ack", a, 1);
        send_byte(8'h05, a);
        chk(a == 1'b1, "R4 first data ack", a, 1);
        chk(wr_cnt == w0 + 1, "R4 one strobe", wr_cnt, w0 + 1);
        chk(wr_last == 8'h05, "R4 strobe data", wr_last, 8'h05);
        send_byte(8'h33, a);
        chk(a == 1'b0, "R4 second data nack", a, 0);
        chk(wr_cnt == w0 + 1, "R4 no extra strobe", wr_cnt, w0 + 1);
        bus_stop();
    endtask

    task automatic t_wrong();
        logic a;
        int o0, w0, g0;
        o0 = oe_rises; w0 = wr_cnt; g0 = gc_cnt;
        bus_start();
        send_byte(8'h90, a);
        chk(a == 1'b0, "R9 other address nack", a, 0);
        send_byte(8'h00, a);
        chk(a == 1'b0, "R9 data after miss nack", a, 0);
        send_byte(8'h06, a);
        chk(a == 1'b0, "R9 reset byte ignored", a, 0);
        chk(oe_rises == o0, "R9 sda never pulled", oe_rises, o0);
        chk(gc_cnt == g0 && wr_cnt == w0, "R9 no strobes", gc_cnt + wr_cnt, g0 + w0);
        bus_stop();
        bus_start();
        send_byte(8'h91, a);
        chk(a == 1'b0, "R1 other read address nack", a, 0);
        bus_stop();
    endtask

    task automatic t_gc();
        logic a;
        int g0, w0;
        g0 = gc_cnt; w0 = wr_cnt;
        bus_start();
        send_byte(8'h00, a);
        chk(a == 1'b1, "R5 general call ack", a, 1);
        send_byte(8'h06, a);
        chk(a == 1'b1, "R5 reset byte ack", a, 1);
        chk(gc_cnt == g0 + 1, "R5 reset strobe", gc_cnt, g0 + 1);
        bus_stop();
        bus_start();
        send_byte(8'h00, a);
        send_byte(8'h04, a);
        chk(a == 1'b1, "R5 04h ack", a, 1);
        chk(gc_cnt == g0 + 1, "R5 04h no strobe", gc_cnt, g0 + 1);
        bus_stop();
        bus_start();
        send_byte(8'h00, a);
        chk(a == 1'b1, "R5 general call ack again", a, 1);
        send_byte(8'h07, a);
        chk(a == 1'b0, "R5 other byte nack", a, 0);
        chk(gc_cnt == g0 + 1, "R5 other byte no strobe", gc_cnt, g0 + 1);
        chk(wr_cnt == w0, "R5 no write strobe", wr_cnt, w0);
        bus_stop();
    endtask

    task automatic t_hs();
        logic a;
        logic [7:0] b;
        result_word = 16'h0123;
        bus_start();
        send_byte(8'h09, a);
        chk(a == 1'b0, "R6 code nack", a, 0);
        chk(hs_mode == 1'b1, "R6 flag set", hs_mode, 1);
        bus_start();
        send_byte(8'h93, a);
        chk(a == 1'b1, "R2 address after restart ack", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'h01, "R3 upper byte in hs", b, 8'h01);
        chk(hs_mode == 1'b1, "R6 flag kept over restart", hs_mode, 1);
        bus_stop();
        chk(hs_mode == 1'b0, "R6 flag cleared by stop", hs_mode, 0);
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] b;
        int w0;
        w0 = wr_cnt;
        result_word = 16'h7ABC;
        bus_start();
        send_byte(8'h92, a);
        chk(a == 1'b1, "R2 write address ack", a, 1);
        bus_start();
        send_byte(8'h93, a);
        chk(a == 1'b1, "R2 read address after restart", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'h7A, "R2 data after restart", b, 8'h7A);
        chk(wr_cnt == w0, "R2 no write strobe", wr_cnt, w0);
        bus_stop();
    endtask

    task automatic t_mnack();
        logic a;
        logic [7:0] b;
        int o0;
        result_word = 16'h3C42;
        bus_start();
        send_byte(8'h93, a);
        recv_byte(1'b0, b);
        chk(b == 8'h3C, "R8 first byte", b, 8'h3C);
        o0 = oe_rises;
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8 released after nack", b, 8'hFF);
        chk(oe_rises == o0, "R8 no pull after nack", oe_rises, o0);
        bus_stop();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_wrong();
        t_gc();
        t_hs();
        t_restart();
        t_mnack();
        chk(oe_bad == 0, "R7 pull only while scl low", oe_bad, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule